// File: doc/BRIEF.md
# Configurable IO Pin Multiplexer

This block sits between a row of IO pad cells and the pins of several peripheral functions. Each pad cell carries a pad input, a pad output and a pad output-enable. Each function pin, which the block calls a lane, is an input, an output or a bidirectional pin. GPIO is treated as one more function. For every pad cell, a selection register picks one of a fixed number of function slots. Slot `j` of cell `k` is wired to lane `k + j`, so neighbouring cells share lanes. One selection value moves the data path and the direction control together. The pad's output-enable therefore always comes from the function that currently drives the pad.

Software reaches the selection registers through a plain request/response port. A request is taken in the cycle where `req_valid` is high; there is no back-pressure. The response appears exactly one cycle later with `rsp_valid` high. It carries an error flag, and for reads also the register value. An index that names no cell is refused with the error flag set.

The routing between pads and lanes is purely combinational from the current register contents.

Top module: `iomux_top`

## Requirements
- R1: After reset every selection register reads 0, so cell `k` routes to lane `k`. `rsp_valid` is low until a request is made.
- R2: A request taken at a clock edge produces `rsp_valid` high for exactly one cycle after that edge. A write whose index `req_addr[IDX_HI:IDX_LO]` is below `N_CELLS` stores `req_wdata[SEL_W-1:0]` into the register of cell `index` and responds with error 0.
- R3: A write whose index is `N_CELLS` or more changes no register and responds with error 1.
- R4: A read of a valid index responds with error 0 and the selection value zero-extended to `DATA_W`. A read changes no register.
- R5: A read of an index of `N_CELLS` or more responds with error 1 and data 0.
- R6: With selection `s < N_FUNCS`, cell `k` uses lane `L = k + s`. Lane kinds follow `L mod 3`: 0 is bidirectional, 1 is output, 2 is input. For a bidirectional lane, the pad output is `fn_out[L]` and the pad output-enable is `fn_oe[L]`. For an output lane, the pad output is `fn_out[L]` and the pad output-enable is 1. For an input lane, both the pad output and the pad output-enable are 0.
- R7: A selection value of `N_FUNCS` or more drives 0 on the cell's pad output and 0 on its pad output-enable.
- R8: An input or bidirectional lane receives `pad_in[k]` of a cell `k` that selects it. A lane that no cell selects receives 0, and an output lane always receives 0.
- R9: When several cells select the same lane, the cell with the lowest number drives that lane's `fn_in`.
- R10: A valid write changes the routing from the clock edge that takes it. Before that edge, the pads still follow the old selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Configuration request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address; bits IDX_HI:IDX_LO give the cell index |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_err | output | 1 | Index does not name a cell |
| rsp_rdata | output | DATA_W | Read data, zero-extended; 0 on error or write |
| pad_in | input | N_CELLS | Input from each pad cell |
| pad_out | output | N_CELLS | Output toward each pad cell |
| pad_oe | output | N_CELLS | Output-enable toward each pad cell |
| fn_out | input | N_LANES | Output value from each function lane |
| fn_oe | input | N_LANES | Output-enable from each function lane (used by bidirectional lanes) |
| fn_in | output | N_LANES | Input delivered to each function lane |

## Verification
A configuration write and the pad routing of the cell being written can fall in the same cycle. Until the edge takes the write, the pads must still show the old selection, and from that edge on they must show the new one. The bench provokes this by presenting a write to cell 3 while an output-lane pattern is applied. It samples `pad_oe[3]` and `pad_out[3]` once before the edge and once after it, and compares each sample with the model of the old and the new selection. The response that the same write produces is checked against the scoreboard queue in the cycle after the edge.

// File: rtl/iomux_pkg.sv
package iomux_pkg;

  typedef enum logic [1:0] {
    LANE_BIDIR = 2'd0,
    LANE_OUT   = 2'd1,
    LANE_IN    = 2'd2
  } lane_kind_e;

  // Fixed map: lane kind repeats every three lanes.
  function automatic lane_kind_e lane_kind(input int lane);
    case (lane % 3)
      0:       return LANE_BIDIR;
      1:       return LANE_OUT;
      default: return LANE_IN;
    endcase
  endfunction

endpackage

// File: rtl/iomux_regbank.sv
module iomux_regbank #(
  parameter int N_CELLS = 4,
  parameter int SEL_W   = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_LO  = 2,
  parameter int IDX_HI  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [N_CELLS*SEL_W-1:0] sel_flat
);
  localparam int IDX_W = IDX_HI - IDX_LO + 1;

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [SEL_W-1:0] sel_q [N_CELLS];
  logic [SEL_W-1:0] rd_val;

  assign idx = req_addr[IDX_HI:IDX_LO];
  assign hit = (32'(idx) < 32'(N_CELLS));

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[k] <= '0;
      else if (req_valid && req_write && hit && (32'(idx) == k))
        sel_q[k] <= req_wdata[SEL_W-1:0];
    end
    assign sel_flat[k*SEL_W +: SEL_W] = sel_q[k];
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N_CELLS; k++)
      if (32'(idx) == k) rd_val = sel_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !hit;
      rsp_rdata <= (req_valid && !req_write && hit) ? DATA_W'(rd_val) : '0;
    end
  end
endmodule

// File: rtl/iomux_pad_route.sv
module iomux_pad_route
  import iomux_pkg::*;
#(
  parameter int CELL    = 0,
  parameter int N_FUNCS = 3,
  parameter int SEL_W   = 2,
  parameter int N_LANES = 6
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [N_LANES-1:0] fn_out,
  input  logic [N_LANES-1:0] fn_oe,
  output logic               pad_out,
  output logic               pad_oe
);
  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    for (int j = 0; j < N_FUNCS; j++) begin
      if (32'(sel) == j) begin
        case (lane_kind(CELL + j))
          LANE_BIDIR: begin
            pad_out = fn_out[CELL + j];
            pad_oe  = fn_oe[CELL + j];
          end
          LANE_OUT: begin
            pad_out = fn_out[CELL + j];
            pad_oe  = 1'b1;
          end
          default: begin
            pad_out = 1'b0;
            pad_oe  = 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/iomux_lane_route.sv
module iomux_lane_route
  import iomux_pkg::*;
#(
  parameter int N_CELLS = 4,
  parameter int N_FUNCS = 3,
  parameter int SEL_W   = 2,
  parameter int N_LANES = 6
) (
  input  logic [N_CELLS*SEL_W-1:0] sel_flat,
  input  logic [N_CELLS-1:0]       pad_in,
  output logic [N_LANES-1:0]       fn_in
);
  always_comb begin
    fn_in = '0;
    for (int l = 0; l < N_LANES; l++) begin
      if (lane_kind(l) != LANE_OUT) begin
        // Scan downward so the lowest-numbered selecting cell is kept.
        for (int k = N_CELLS - 1; k >= 0; k--) begin
          if ((32'(sel_flat[k*SEL_W +: SEL_W]) < N_FUNCS) &&
              (k + 32'(sel_flat[k*SEL_W +: SEL_W]) == l))
            fn_in[l] = pad_in[k];
        end
      end
    end
  end
endmodule

// File: rtl/iomux_top.sv
module iomux_top #(
  parameter int N_CELLS = 4,
  parameter int N_FUNCS = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_LO  = 2,
  parameter int IDX_HI  = 5,
  localparam int SEL_W   = (N_FUNCS > 1) ? $clog2(N_FUNCS) : 1,
  localparam int N_LANES = N_CELLS + N_FUNCS - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [N_CELLS-1:0] pad_in,
  output logic [N_CELLS-1:0] pad_out,
  output logic [N_CELLS-1:0] pad_oe,
  input  logic [N_LANES-1:0] fn_out,
  input  logic [N_LANES-1:0] fn_oe,
  output logic [N_LANES-1:0] fn_in
);
  logic [N_CELLS*SEL_W-1:0] sel_flat;

  iomux_regbank #(
    .N_CELLS(N_CELLS), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .sel_flat(sel_flat)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_pad
    iomux_pad_route #(
      .CELL(k), .N_FUNCS(N_FUNCS), .SEL_W(SEL_W), .N_LANES(N_LANES)
    ) u_pad (
      .sel(sel_flat[k*SEL_W +: SEL_W]),
      .fn_out(fn_out), .fn_oe(fn_oe),
      .pad_out(pad_out[k]), .pad_oe(pad_oe[k])
    );
  end

  iomux_lane_route #(
    .N_CELLS(N_CELLS), .N_FUNCS(N_FUNCS), .SEL_W(SEL_W), .N_LANES(N_LANES)
  ) u_lanes (
    .sel_flat(sel_flat), .pad_in(pad_in), .fn_in(fn_in)
  );
endmodule

// File: rtl/iomux_checker.sv
module iomux_checker
  import iomux_pkg::*;
#(
  parameter int N_CELLS = 4,
  parameter int N_FUNCS = 3,
  parameter int SEL_W   = 2,
  parameter int N_LANES = 6,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_LO  = 2,
  parameter int IDX_HI  = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     rsp_valid,
  input logic                     rsp_err,
  input logic [DATA_W-1:0]        rsp_rdata,
  input logic [N_CELLS-1:0]       pad_out,
  input logic [N_CELLS-1:0]       pad_oe,
  input logic [N_LANES-1:0]       fn_in,
  input logic [N_CELLS*SEL_W-1:0] sel_flat
);
  logic bad_idx;
  assign bad_idx = 32'(req_addr[IDX_HI:IDX_LO]) >= N_CELLS;

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r5_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  a_r3_bad_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && bad_idx) |=> $stable(sel_flat));

  a_r4_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> $stable(sel_flat));

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell_chk
    a_r7_out_of_range_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(sel_flat[k*SEL_W +: SEL_W]) >= N_FUNCS) |-> (!pad_oe[k] && !pad_out[k]));
  end

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane_chk
    if (lane_kind(l) == LANE_OUT) begin : g_out
      a_r8_output_lane_no_input: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_in[l]);
    end
  end
endmodule

bind iomux_top iomux_checker #(
  .N_CELLS(N_CELLS), .N_FUNCS(N_FUNCS), .SEL_W(SEL_W), .N_LANES(N_LANES),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .fn_in(fn_in), .sel_flat(sel_flat)
);

// File: tb/iomux_top_bench.sv
module iomux_top_bench;
  localparam int NC = 4;
  localparam int NF = 3;
  localparam int NL = NC + NF - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] pad_in = '0;
  logic [NC-1:0] pad_out, pad_oe;
  logic [NL-1:0] fn_out = '0, fn_oe = '0;
  logic [NL-1:0] fn_in;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int sel_m [NC];

  bit          exp_err_q [$];
  logic [31:0] exp_data_q [$];
  string       exp_tag_q [$];

  always #5 clk = ~clk;

  iomux_top u_iomux_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe),
    .fn_in(fn_in)
  );

  function automatic int kind_m(int l);
    return l % 3; // 0 bidir, 1 output, 2 input
  endfunction

  function automatic logic [1:0] exp_pad(int k); // {out, oe}
    int lane;
    if (sel_m[k] >= NF) return 2'b00;
    lane = k + sel_m[k];
    case (kind_m(lane))
      0:       return {fn_out[lane], fn_oe[lane]};
      1:       return {fn_out[lane], 1'b1};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic exp_lane(int l);
    if (kind_m(l) == 1) return 1'b0;
    for (int k = 0; k < NC; k++)
      if (sel_m[k] < NF && k + sel_m[k] == l) return pad_in[k];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_err_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", 32'(rsp_valid), 32'h0);
      end else begin
        bit e; logic [31:0] d; string t;
        e = exp_err_q.pop_front();
        d = exp_data_q.pop_front();
        t = exp_tag_q.pop_front();
        check(rsp_err == e && rsp_rdata == d, t, {rsp_err, rsp_rdata[30:0]}, {e, d[30:0]});
      end
    end
  end

  // Driver: one request, pushes the expected response.
  task automatic do_req(input bit wr, input int idx, input logic [31:0] d,
                        input string tag);
    bit e;
    logic [31:0] ed;
    e  = (idx >= NC);
    ed = (!wr && !e) ? 32'(sel_m[idx]) : 32'h0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr = 8'(idx << 2); req_wdata = d;
    exp_err_q.push_back(e); exp_data_q.push_back(ed); exp_tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr && !e) sel_m[idx] = int'(d[1:0]);
  endtask

  task automatic check_routes(input logic [NC-1:0] pi, input logic [NL-1:0] fo,
                              input logic [NL-1:0] foe, input string tag);
    logic [NC-1:0] eo, ee;
    logic [NL-1:0] el;
    @(negedge clk);
    pad_in = pi; fn_out = fo; fn_oe = foe;
    #1;
    for (int k = 0; k < NC; k++) {eo[k], ee[k]} = exp_pad(k);
    for (int l = 0; l < NL; l++) el[l] = exp_lane(l);
    check(pad_out == eo && pad_oe == ee, {tag, " pads"},
          32'({pad_out, pad_oe}), 32'({eo, ee}));
    check(fn_in == el, {tag, " lanes"}, 32'(fn_in), 32'(el));
  endtask

  task automatic route_sweep(input string tag);
    check_routes(4'b1010, 6'b110101, 6'b011011, tag);
    check_routes(4'b0101, 6'b001010, 6'b100100, tag);
    check_routes(4'b1111, 6'b111111, 6'b000000, tag);
    check_routes(4'b0011, 6'b010110, 6'b111111, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) sel_m[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);
    for (int k = 0; k < NC; k++) do_req(1'b0, k, 32'h0, "R1 R4 reset value read");
    route_sweep("R1 R6 R8 reset routing");

    // Writes: truncation, shared lanes, out-of-range selection
    do_req(1'b1, 0, 32'hFFFF_FFFE, "R2 write truncated");
    do_req(1'b1, 1, 32'h0000_0001, "R2 write cell1");
    do_req(1'b1, 2, 32'h0000_0000, "R2 write cell2");
    do_req(1'b1, 3, 32'h0000_0003, "R2 write cell3 out of range");
    for (int k = 0; k < NC; k++) do_req(1'b0, k, 32'h0, "R4 read back");
    route_sweep("R9 R7 R8 lane conflict routing");

    // Invalid index writes and reads
    do_req(1'b1, 5, 32'h0000_0001, "R3 bad write error");
    do_req(1'b1, 15, 32'h0000_0002, "R3 bad write error top index");
    for (int k = 0; k < NC; k++) do_req(1'b0, k, 32'h0, "R3 registers unchanged");
    do_req(1'b0, 9, 32'h0, "R5 bad read error and zero data");
    do_req(1'b0, 4, 32'h0, "R5 bad read first invalid index");

    // Other selections: bidir and output lanes on several cells
    do_req(1'b1, 0, 32'h1, "R2 write cell0 output lane");
    do_req(1'b1, 1, 32'h2, "R2 write cell1 bidir lane");
    do_req(1'b1, 2, 32'h1, "R2 write cell2 bidir lane");
    route_sweep("R6 R8 bidir and output routing");

    // R10: write and routing of the same cell in one cycle
    @(negedge clk);
    pad_in = 4'b0000; fn_out = 6'b010000; fn_oe = 6'b000000;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h0C; req_wdata = 32'h1;
    exp_err_q.push_back(1'b0); exp_data_q.push_back(32'h0);
    exp_tag_q.push_back("R10 write response");
    #1;
    check(pad_oe[3] == 1'b0 && pad_out[3] == 1'b0, "R10 old selection before edge",
          32'({pad_out[3], pad_oe[3]}), 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    sel_m[3] = 1;
    check(pad_oe[3] == 1'b1 && pad_out[3] == 1'b1, "R10 new selection after edge",
          32'({pad_out[3], pad_oe[3]}), 32'h3);
    route_sweep("R10 R6 routing after update");

    repeat (3) @(negedge clk);
    check(exp_err_q.size() == 0, "R2 all responses seen", 32'(exp_err_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule